// File: doc/BRIEF.md
# 8-bit ALU with Condition Codes

This block is the arithmetic core of a small accumulator machine. It takes two 8-bit operands, a 3-bit operation code and an incoming carry bit. In the same cycle it returns an 8-bit result and a proposed five-bit set of condition flags: half carry H, negative N, zero Z, overflow V and carry C. The operations are add, subtract, increment, decrement, rotate right and rotate left through the carry, and a pass-through of the first operand.

A condition-code holder is part of the block. It has a write enable for each flag. On a rising clock edge, each enabled flag loads its proposed value and every other flag keeps its value. Some operations leave a flag alone, for example increment and decrement leave the carry. For those flags the proposed value is the one already in the holder, so the same write enables can be applied to every operation.

The carry input feeds only the two rotates. The surrounding datapath usually wires the held C back to it, but it is a port of its own so that the rotates can be driven independently.

Top module: `alu8_cc_top`

## Requirements
- R1: With op 3'd1 (add), result = (a + b) mod 256, and flag C is the carry out of bit 7. Example: 0x3D + 0xE2 gives 0x1F with C=1.
- R2: With op 3'd1, flag H is the carry out of bit 3. Example: 0xBD + 0xA3 gives 0x60 with H=1 and V=1. With ops 3'd0, 3'd2 to 3'd7, H is proposed as the held H.
- R3: Flag V is the two's-complement overflow. On add it is set when the two operands have the same sign and the result has the other sign. On subtract it is set when the operands differ in sign and the result's sign differs from a's.
- R4: With op 3'd2 (subtract), result = (a - b) mod 256, and C = 1 exactly when a < b unsigned (a borrow).
- R5: With op 3'd3 (increment) result = a + 1, and with op 3'd4 (decrement) result = a - 1. V is set only for 0x7F incremented or 0x80 decremented. C is proposed as the held C.
- R6: With op 3'd5 (rotate right) result = {carry_i, a[7:1]} and C = a[0]. With op 3'd6 (rotate left) result = {a[6:0], carry_i} and C = a[7]. For both rotates V = N xor C.
- R7: For every operation, Z = 1 exactly when all 8 result bits are 0, and N = result bit 7.
- R8: With op 3'd0 (pass) or op 3'd7 (reserved, treated as pass), result = a and V = 0. C is proposed as the held C.
- R9: Flag bit positions are C=0, V=1, Z=2, N=3, H=4 in flags_o, ccr_o and flag_we_i. On a rising edge, ccr_o bit k loads flags_o bit k when flag_we_i bit k is 1, and keeps its value otherwise.
- R10: While rst_n is low, ccr_o is 5'b00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag holder |
| rst_n | input | 1 | Active-low synchronous reset of the flag holder |
| a_i | input | 8 | First operand (accumulator) |
| b_i | input | 8 | Second operand |
| op_i | input | 3 | Operation code |
| carry_i | input | 1 | Carry shifted in by the rotates |
| flag_we_i | input | 5 | Write enable for each flag |
| result_o | output | 8 | Combinational result |
| flags_o | output | 5 | Proposed flags for this operation |
| ccr_o | output | 5 | Held condition flags |

## Verification
The hardest case to reach is an operation that leaves a flag alone while the holder has a non-trivial value in that flag. Such a case shows whether the held value is proposed, or whether a fresh or stale value leaks through. Reaching it takes two steps. First, selective writes load known H and C values into the holder. Then an increment, decrement or pass follows with its write enables closed, so the proposed held flags can be compared with the bench's own copy of the holder. Random runs mix ops with random enable masks, so the holder walks through many patterns between these steps.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_ROR  = 3'd5,
        OP_ROL  = 3'd6,
        OP_RSVD = 3'd7
    } alu_op_e;

    localparam int NFLAGS = 5;
    localparam int FLG_C  = 0;
    localparam int FLG_V  = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_N  = 3;
    localparam int FLG_H  = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LOW_W  = 4
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] sum,
    output logic              carry_top,
    output logic              carry_low,
    output logic              ovf
);

    logic [DATA_W-1:0] y;
    logic              cin;
    logic [DATA_W:0]   full;
    logic [LOW_W:0]    low;

    always_comb begin
        unique case (op)
            OP_ADD:  begin y = opb;                          cin = 1'b0; end
            OP_SUB:  begin y = ~opb;                         cin = 1'b1; end
            OP_INC:  begin y = {{(DATA_W-1){1'b0}}, 1'b1};   cin = 1'b0; end
            OP_DEC:  begin y = {DATA_W{1'b1}};               cin = 1'b0; end
            default: begin y = '0;                           cin = 1'b0; end
        endcase
    end

    assign full      = {1'b0, opa} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    assign low       = {1'b0, opa[LOW_W-1:0]} + {1'b0, y[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
    assign sum       = full[DATA_W-1:0];
    assign carry_top = full[DATA_W];
    assign carry_low = low[LOW_W];
    assign ovf       = (opa[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != opa[DATA_W-1]);

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic              cin,
    input  logic              to_left,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    always_comb begin
        if (to_left) begin
            res  = {opa[DATA_W-2:0], cin};
            cout = opa[DATA_W-1];
        end else begin
            res  = {cin, opa[DATA_W-1:1]};
            cout = opa[0];
        end
    end

endmodule

// File: rtl/alu8_flag_hold.sv
module alu8_flag_hold #(
    parameter int NF = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] we,
    input  logic [NF-1:0] d,
    output logic [NF-1:0] q
);

    for (genvar k = 0; k < NF; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[k] <= 1'b0;
            end else if (we[k]) begin
                q[k] <= d[k];
            end
        end
    end

endmodule

// File: rtl/alu8_cc_top.sv
module alu8_cc_top
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [2:0]        op_i,
    input  logic              carry_i,
    input  logic [4:0]        flag_we_i,
    output logic [DATA_W-1:0] result_o,
    output logic [4:0]        flags_o,
    output logic [4:0]        ccr_o
);

    localparam int LOW_W = DATA_W / 2;

    alu_op_e           op;
    logic [DATA_W-1:0] as_sum;
    logic              as_ctop;
    logic              as_clow;
    logic              as_ovf;
    logic [DATA_W-1:0] rot_res;
    logic              rot_cout;
    logic              n_f;
    logic              z_f;
    logic              v_f;
    logic              c_f;
    logic              h_f;

    assign op = alu_op_e'(op_i);

    alu8_addsub #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_addsub (
        .opa       (a_i),
        .opb       (b_i),
        .op        (op),
        .sum       (as_sum),
        .carry_top (as_ctop),
        .carry_low (as_clow),
        .ovf       (as_ovf)
    );

    alu8_rotate #(.DATA_W(DATA_W)) u_rot (
        .opa     (a_i),
        .cin     (carry_i),
        .to_left (op == OP_ROL),
        .res     (rot_res),
        .cout    (rot_cout)
    );

    always_comb begin
        h_f = ccr_o[FLG_H];
        c_f = ccr_o[FLG_C];
        v_f = 1'b0;
        unique case (op)
            OP_ADD: begin
                result_o = as_sum;
                c_f      = as_ctop;
                h_f      = as_clow;
                v_f      = as_ovf;
            end
            OP_SUB: begin
                result_o = as_sum;
                c_f      = ~as_ctop;
                v_f      = as_ovf;
            end
            OP_INC, OP_DEC: begin
                result_o = as_sum;
                v_f      = as_ovf;
            end
            OP_ROR, OP_ROL: begin
                result_o = rot_res;
                c_f      = rot_cout;
                v_f      = rot_res[DATA_W-1] ^ rot_cout;
            end
            default: begin
                result_o = a_i;
            end
        endcase
    end

    assign n_f = result_o[DATA_W-1];
    assign z_f = ~|result_o;

    always_comb begin
        flags_o        = '0;
        flags_o[FLG_C] = c_f;
        flags_o[FLG_V] = v_f;
        flags_o[FLG_Z] = z_f;
        flags_o[FLG_N] = n_f;
        flags_o[FLG_H] = h_f;
    end

    alu8_flag_hold #(.NF(NFLAGS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we_i),
        .d     (flags_o),
        .q     (ccr_o)
    );

endmodule

// File: rtl/alu8_cc_chk.sv
module alu8_cc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] a_i,
    input logic [7:0] b_i,
    input logic [2:0] op_i,
    input logic       carry_i,
    input logic [4:0] flag_we_i,
    input logic [7:0] result_o,
    input logic [4:0] flags_o,
    input logic [4:0] ccr_o
);

    // R1: carry of an add matches the 9-bit sum
    a_r1_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |-> (flags_o[0] == ({1'b0, a_i} + {1'b0, b_i} > 9'd255)));

    // R3: add overflow by sign rule
    a_r3_add_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |-> (flags_o[1] == ((a_i[7] == b_i[7]) && (result_o[7] != a_i[7]))));

    // R4: subtract borrow
    a_r4_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |-> (flags_o[0] == (a_i < b_i)));

    // R5: increment and decrement propose the held carry
    a_r5_incdec_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd3) || (op_i == 3'd4)) |-> (flags_o[0] == ccr_o[0]));

    // R6: rotate right shifts the carry in at the top
    a_r6_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |-> ((result_o[7] == carry_i) && (flags_o[0] == a_i[0])));

    // R9: a closed enable holds the whole register
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i == 5'b0) |=> $stable(ccr_o));

    // R9: an open carry enable loads the proposed carry
    a_r9_load_c: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i[0] |=> (ccr_o[0] == $past(flags_o[0])));

    // R10: reset clears the holder
    a_r10_reset: assert property (@(posedge clk)
        (!rst_n) |=> (ccr_o == 5'b0));

endmodule

bind alu8_cc_top alu8_cc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_i       (a_i),
    .b_i       (b_i),
    .op_i      (op_i),
    .carry_i   (carry_i),
    .flag_we_i (flag_we_i),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .ccr_o     (ccr_o)
);

// File: tb/tb_alu8_cc_top.sv
`timescale 1ns/1ps
module tb_alu8_cc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [2:0] op_i = '0;
    logic       carry_i = 1'b0;
    logic [4:0] flag_we_i = '0;
    logic [7:0] result_o;
    logic [4:0] flags_o;
    logic [4:0] ccr_o;

    int   n_run = 0;
    int   n_fail = 0;
    logic [4:0] mccr = '0;

    always #2 clk = ~clk;

    alu8_cc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_i       (a_i),
        .b_i       (b_i),
        .op_i      (op_i),
        .carry_i   (carry_i),
        .flag_we_i (flag_we_i),
        .result_o  (result_o),
        .flags_o   (flags_o),
        .ccr_o     (ccr_o)
    );

    // returns {H,N,Z,V,C, result}
    function automatic logic [12:0] model(input logic [7:0] a, input logic [7:0] b,
                                          input logic [2:0] op, input logic cin,
                                          input logic [4:0] held);
        logic [7:0] r;
        logic h, v, c;
        int   s;
        h = held[4];
        c = held[0];
        v = 1'b0;
        case (op)
            3'd1: begin
                s = int'(a) + int'(b);
                r = s[7:0];
                c = (s > 255);
                h = ((int'(a[3:0]) + int'(b[3:0])) > 15);
                v = (a[7] == b[7]) && (r[7] != a[7]);
            end
            3'd2: begin
                r = a - b;
                c = (a < b);
                v = (a[7] != b[7]) && (r[7] != a[7]);
            end
            3'd3: begin r = a + 8'd1; v = (a == 8'h7F); end
            3'd4: begin r = a - 8'd1; v = (a == 8'h80); end
            3'd5: begin r = {cin, a[7:1]}; c = a[0]; v = r[7] ^ c; end
            3'd6: begin r = {a[6:0], cin}; c = a[7]; v = r[7] ^ c; end
            default: begin r = a; end
        endcase
        return {h, r[7], (r == 8'h00), v, c, r};
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd1: return "R1/R2/R3";
            3'd2: return "R4/R3";
            3'd3, 3'd4: return "R5";
            3'd5, 3'd6: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check combinational outputs, clock, check holder
    task automatic step(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op,
                        input logic cin, input logic [4:0] we, input string req);
        logic [12:0] e;
        @(negedge clk);
        a_i = a; b_i = b; op_i = op; carry_i = cin; flag_we_i = we;
        #1;
        e = model(a, b, op, cin, mccr);
        check({req, " result"}, 32'(result_o), 32'(e[7:0]));
        check({req, " flags"}, 32'(flags_o), 32'(e[12:8]));
        @(posedge clk);
        for (int k = 0; k < 5; k++) if (we[k]) mccr[k] = e[8+k];
        #1;
        check("R9 holder", 32'(ccr_o), 32'(mccr));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", 32'(ccr_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corner cases
        step(8'h3D, 8'hE2, 3'd1, 1'b0, 5'h1F, "R1 3D+E2");
        check("R1 sum 1F", 32'(result_o), 32'h1F);
        step(8'hBD, 8'hA3, 3'd1, 1'b0, 5'h1F, "R2 BD+A3");
        check("R2 H set", 32'(ccr_o[4]), 32'h1);
        step(8'h7F, 8'h01, 3'd1, 1'b0, 5'h1F, "R3 add ovf");
        step(8'h80, 8'h01, 3'd2, 1'b0, 5'h1F, "R3 sub ovf");
        step(8'h00, 8'h01, 3'd2, 1'b0, 5'h1F, "R4 borrow");
        step(8'h05, 8'h05, 3'd2, 1'b0, 5'h1F, "R7 zero");
        // seed H and C to 1, then increment with enables closed except V
        step(8'hFF, 8'hFF, 3'd1, 1'b0, 5'h1F, "R2 seed H,C");
        step(8'h7F, 8'h00, 3'd3, 1'b0, 5'h02, "R5 inc 7F");
        step(8'h80, 8'h00, 3'd4, 1'b0, 5'h1F, "R5 dec 80");
        step(8'hFF, 8'h00, 3'd3, 1'b0, 5'h1F, "R5 inc wrap");
        step(8'h01, 8'h00, 3'd5, 1'b1, 5'h1F, "R6 ror");
        step(8'h80, 8'h00, 3'd6, 1'b0, 5'h1F, "R6 rol");
        step(8'hA5, 8'h3C, 3'd0, 1'b0, 5'h1F, "R8 pass");
        step(8'h00, 8'h11, 3'd7, 1'b1, 5'h1F, "R8 reserved");
        step(8'h12, 8'hF0, 3'd1, 1'b0, 5'h00, "R9 hold all");
        step(8'h80, 8'h80, 3'd1, 1'b0, 5'h01, "R9 carry only");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            op = 3'($urandom);
            step(8'($urandom), 8'($urandom), op, 1'($urandom), 5'($urandom), req_of(op));
        end

        // reset after holder loaded
        step(8'hFF, 8'hFF, 3'd1, 1'b0, 5'h1F, "R9 preload");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10 reset clears", 32'(ccr_o), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule